// File: doc/BRIEF.md
# Banked Clock Fanout with Shared Half-Rate Divider

This block picks one reference clock out of three candidates and spreads it across four output banks of 2, 3, 4 and 6 outputs, 15 outputs in all. Two of the candidates are single-ended clocks. The third is a differential pair, modelled digitally as a comparator that reads high when the positive leg is high and the negative leg is low. Each bank has its own rate bit. With the bit clear the bank carries the selected clock unchanged. With the bit set the bank carries that clock divided by two.

All half-rate banks draw from one toggle register clocked by the selected source, so every half-rate output switches on the same source edge. Half-rate and full-rate banks are also in phase: a half-rate rising edge always lines up with a full-rate rising edge. A single hold input does two things. It clears the divider on source edges, and it drops the drive enable of every bank. The enable stands for the high-impedance state of the outputs. All selects and the hold input rest low, which gives the first single-ended clock, every bank at full rate, and outputs driven.

Top module: `clk_fanout_banks`

## Requirements
- R1: With `use_diff_i` low, the selected source is `ref0_i` when `pick_ref1_i` is low and `ref1_i` when it is high.
- R2: With `use_diff_i` high, the selected source is the differential pair, which reads 1 when `refp_i` is 1 and `refn_i` is 0, and 0 otherwise.
- R3: A bank whose rate bit is 0 outputs the selected source clock: one output period per source period.
- R4: A bank whose rate bit is 1 outputs a single shared divide-by-two of the source. It toggles on every source rising edge while hold is low, giving one output period per two source periods. All half-rate banks are identical.
- R5: While `hold_i` is 1, all four bits of `drive_en_o` are 0 (outputs in high impedance). While it is 0, all four bits are 1.
- R6: On source rising edges with `hold_i` at 1, the divider is forced to 0. After release, half-rate outputs stay 0 until the first source rising edge. That edge drives them to 1, in the same step as the full-rate outputs go to 1.
- R7: All outputs inside one bank carry the same value at all times.
- R8: Bit 0 of `half_sel_i` controls bank A, bit 1 bank B, bit 2 bank C and bit 3 bank D. The bits act independently, so banks may run in mixed modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref0_i | input | 1 | First single-ended reference clock |
| ref1_i | input | 1 | Second single-ended reference clock |
| refp_i | input | 1 | Positive leg of the differential reference |
| refn_i | input | 1 | Negative leg of the differential reference |
| pick_ref1_i | input | 1 | Single-ended choice: 0 picks ref0_i, 1 picks ref1_i |
| use_diff_i | input | 1 | 1 selects the differential reference over the single-ended choice |
| half_sel_i | input | 4 | Per-bank rate bit, bit 0 = bank A ... bit 3 = bank D; 1 = half rate |
| hold_i | input | 1 | Divider clear and output disable, active high |
| bank_a_o | output | 2 | Bank A clock outputs |
| bank_b_o | output | 3 | Bank B clock outputs |
| bank_c_o | output | 4 | Bank C clock outputs |
| bank_d_o | output | 6 | Bank D clock outputs |
| drive_en_o | output | 4 | Per-bank drive enable, bit order as half_sel_i; 0 = high impedance |

## Verification
The clocked properties take three things for granted. First, the selected source keeps running while `hold_i` is high, because the divider is cleared only on source edges. Second, the source selects and rate bits change only while hold is asserted. Third, the differential legs are complementary. The stimulus follows all three rules. Every configuration is loaded under hold, the divider is cleared through at least three source edges, and hold is released a short time after a source edge, so no edge coincides with a select change. The differential negative leg is driven as the inverse of the positive leg.

// File: rtl/fanout_pkg.sv
package fanout_pkg;

  typedef enum logic [1:0] {
    SRC_REF0 = 2'd0,
    SRC_REF1 = 2'd1,
    SRC_DIFF = 2'd2
  } src_e;

  localparam int NUM_BANKS = 4;

  // Differential pick overrides the single-ended choice.
  function automatic src_e decode_src(input logic pick1, input logic diff);
    if (diff)       return SRC_DIFF;
    else if (pick1) return SRC_REF1;
    else            return SRC_REF0;
  endfunction

endpackage

// File: rtl/fo_src_mux.sv
module fo_src_mux
  import fanout_pkg::*;
(
  input  logic ref0_i,
  input  logic ref1_i,
  input  logic refp_i,
  input  logic refn_i,
  input  logic pick_ref1_i,
  input  logic use_diff_i,
  output logic src_o
);

  logic diff_rx;
  src_e sel;

  // digital stand-in for a differential receiver
  assign diff_rx = refp_i & ~refn_i;
  assign sel     = decode_src(pick_ref1_i, use_diff_i);

  always_comb begin
    case (sel)
      SRC_REF0: src_o = ref0_i;
      SRC_REF1: src_o = ref1_i;
      SRC_DIFF: src_o = diff_rx;
      default:  src_o = ref0_i;
    endcase
  end

endmodule

// File: rtl/fo_half_div.sv
module fo_half_div (
  input  logic ck_i,
  input  logic clr_i,
  output logic half_o
);

  // one toggle stage shared by every half-rate bank
  always_ff @(posedge ck_i) begin
    if (clr_i) half_o <= 1'b0;
    else       half_o <= ~half_o;
  end

endmodule

// File: rtl/fo_bank.sv
module fo_bank #(
  parameter int W = 2
) (
  input  logic         full_i,
  input  logic         half_i,
  input  logic         rate_i,
  input  logic         hold_i,
  output logic [W-1:0] q_o,
  output logic         en_o
);

  logic pick;

  assign pick = rate_i ? half_i : full_i;
  assign q_o  = {W{pick}};
  assign en_o = ~hold_i;

endmodule

// File: rtl/clk_fanout_banks.sv
module clk_fanout_banks
  import fanout_pkg::*;
#(
  parameter int W_A = 2,
  parameter int W_B = 3,
  parameter int W_C = 4,
  parameter int W_D = 6
) (
  input  logic                 ref0_i,
  input  logic                 ref1_i,
  input  logic                 refp_i,
  input  logic                 refn_i,
  input  logic                 pick_ref1_i,
  input  logic                 use_diff_i,
  input  logic [NUM_BANKS-1:0] half_sel_i,
  input  logic                 hold_i,
  output logic [W_A-1:0]       bank_a_o,
  output logic [W_B-1:0]       bank_b_o,
  output logic [W_C-1:0]       bank_c_o,
  output logic [W_D-1:0]       bank_d_o,
  output logic [NUM_BANKS-1:0] drive_en_o
);

  localparam int TOTAL = W_A + W_B + W_C + W_D;
  localparam int BW  [NUM_BANKS] = '{W_A, W_B, W_C, W_D};
  localparam int BOFF[NUM_BANKS] = '{0, W_A, W_A + W_B, W_A + W_B + W_C};

  logic             src_ck;
  logic             half_q;
  logic [TOTAL-1:0] all_q;

  fo_src_mux u_mux (
    .ref0_i      (ref0_i),
    .ref1_i      (ref1_i),
    .refp_i      (refp_i),
    .refn_i      (refn_i),
    .pick_ref1_i (pick_ref1_i),
    .use_diff_i  (use_diff_i),
    .src_o       (src_ck)
  );

  fo_half_div u_div (
    .ck_i   (src_ck),
    .clr_i  (hold_i),
    .half_o (half_q)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fo_bank #(.W(BW[b])) u_bank (
      .full_i (src_ck),
      .half_i (half_q),
      .rate_i (half_sel_i[b]),
      .hold_i (hold_i),
      .q_o    (all_q[BOFF[b] +: BW[b]]),
      .en_o   (drive_en_o[b])
    );
  end

  assign bank_a_o = all_q[BOFF[0] +: W_A];
  assign bank_b_o = all_q[BOFF[1] +: W_B];
  assign bank_c_o = all_q[BOFF[2] +: W_C];
  assign bank_d_o = all_q[BOFF[3] +: W_D];

endmodule

// File: rtl/fo_checker.sv
module fo_checker #(
  parameter int W_A = 2,
  parameter int W_B = 3,
  parameter int W_C = 4,
  parameter int W_D = 6
) (
  input logic           src_ck,
  input logic           hold,
  input logic           half_q,
  input logic [3:0]     rate,
  input logic [W_A-1:0] q_a,
  input logic [W_B-1:0] q_b,
  input logic [W_C-1:0] q_c,
  input logic [W_D-1:0] q_d,
  input logic [3:0]     en
);

  // R4: the shared divider toggles on every source edge out of hold
  a_r4_toggle_each_edge: assert property (@(posedge src_ck) disable iff (hold)
    !$past(hold) |-> half_q != $past(half_q));

  // R6: the first edge after release sees a cleared divider
  a_r6_start_low: assert property (@(posedge src_ck) disable iff (hold)
    $past(hold) |-> half_q == 1'b0);

  // R4: half-rate banks carry the shared divider
  a_r4_bank_a_half: assert property (@(posedge src_ck) disable iff (hold)
    rate[0] |-> q_a == {W_A{half_q}});
  a_r4_bank_d_half: assert property (@(posedge src_ck) disable iff (hold)
    rate[3] |-> q_d == {W_D{half_q}});

  // R4: two half-rate banks never disagree
  a_r4_cross_bank: assert property (@(posedge src_ck) disable iff (hold)
    (rate[1] && rate[2]) |-> q_b[0] == q_c[0]);

  // R7: one value per bank
  a_r7_bank_c_uniform: assert property (@(posedge src_ck) disable iff (hold)
    (q_c == '0) || (q_c == '1));

  // R5: enables follow hold
  always_comb begin
    if (!$isunknown(hold)) begin
      a_r5_enables: assert (en == (hold ? 4'b0000 : 4'b1111));
    end
  end

endmodule

bind clk_fanout_banks fo_checker #(
  .W_A(W_A), .W_B(W_B), .W_C(W_C), .W_D(W_D)
) u_chk (
  .src_ck (src_ck),
  .hold   (hold_i),
  .half_q (half_q),
  .rate   (half_sel_i),
  .q_a    (bank_a_o),
  .q_b    (bank_b_o),
  .q_c    (bank_c_o),
  .q_d    (bank_d_o),
  .en     (drive_en_o)
);

// File: tb/tb_clk_fanout_banks.sv
module tb_clk_fanout_banks;

  // 125 MHz bench clock doubles as the first reference
  logic r0 = 1'b0, r1 = 1'b0, dp = 1'b0;
  logic dn;
  always #4  r0 = ~r0;
  always #6  r1 = ~r1;
  always #10 dp = ~dp;
  assign dn = ~dp;

  logic       hold = 1'b1, pick1 = 1'b0, pickd = 1'b0;
  logic [3:0] rsel = 4'b0000;
  logic [1:0] qa;
  logic [2:0] qb;
  logic [3:0] qc;
  logic [5:0] qd;
  logic [3:0] en;

  clk_fanout_banks dut (
    .ref0_i(r0), .ref1_i(r1), .refp_i(dp), .refn_i(dn),
    .pick_ref1_i(pick1), .use_diff_i(pickd), .half_sel_i(rsel), .hold_i(hold),
    .bank_a_o(qa), .bank_b_o(qb), .bank_c_o(qc), .bank_d_o(qd), .drive_en_o(en)
  );

  // expected source from R1/R2
  logic tb_src;
  always_comb tb_src = pickd ? (dp & ~dn) : (pick1 ? r1 : r0);

  int cnt [4];
  always @(posedge qa[0]) cnt[0]++;
  always @(posedge qb[0]) cnt[1]++;
  always @(posedge qc[0]) cnt[2]++;
  always @(posedge qd[0]) cnt[3]++;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic bank_bit(input int b);
    case (b)
      0: return qa[0];
      1: return qb[0];
      2: return qc[0];
      default: return qd[0];
    endcase
  endfunction

  function automatic bit bank_same(input int b);
    case (b)
      0: return (qa == '0) || (qa == '1);
      1: return (qb == '0) || (qb == '1);
      2: return (qc == '0) || (qc == '1);
      default: return (qd == '0) || (qd == '1);
    endcase
  endfunction

  task automatic run_cfg(input int s, input int m);
    string stag;
    bit ok_all;
    stag = (s == 2) ? "R2" : "R1";
    hold  = 1'b1;
    pick1 = (s == 1);
    pickd = (s == 2);
    rsel  = m[3:0];
    repeat (3) @(posedge tb_src);
    #1;
    chk(en == 4'b0000, "R5", en, 0);
    for (int b = 0; b < 4; b++)
      if (rsel[b]) chk(bank_bit(b) == 1'b0, "R6", bank_bit(b), 0);
    hold = 1'b0;
    #1;
    chk(en == 4'b1111, "R5", en, 15);
    for (int b = 0; b < 4; b++)
      if (rsel[b]) chk(bank_bit(b) == 1'b0, "R6", bank_bit(b), 0);
    @(posedge tb_src);
    #1;
    for (int b = 0; b < 4; b++)
      chk(bank_bit(b) == 1'b1, rsel[b] ? "R6" : "R3", bank_bit(b), 1);
    for (int b = 0; b < 4; b++) cnt[b] = 0;
    repeat (16) @(posedge tb_src);
    #1;
    ok_all = 1;
    for (int b = 0; b < 4; b++) begin
      int exp_n;
      exp_n = rsel[b] ? 8 : 16;
      if (cnt[b] != exp_n) ok_all = 0;
      chk(cnt[b] == exp_n, (m == 0) ? stag : (rsel[b] ? "R4" : "R3"), cnt[b], exp_n);
      chk(bank_same(b), "R7", b, b);
    end
    if (m != 0 && m != 15) chk(ok_all, "R8", m, m);
  endtask

  initial begin
    // reset state: hold high from time zero, defaults elsewhere
    #30;
    chk(en == 4'b0000, "R5", en, 0);
    chk(qa[0] == r0, "R1", qa[0], r0);
    for (int s = 0; s < 3; s++)
      for (int m = 0; m < 16; m++)
        run_cfg(s, m);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule